// File: doc/BRIEF.md
# FIFO Flag Offset Programming Unit

This block hands a FIFO its two threshold offsets: the almost-empty offset, counted in words up from the empty boundary, and the almost-full offset, counted in words down from the full boundary. While the master reset is held, a two-bit threshold select and a serial-mode select are sampled on every clock edge. The last sample decides how the offsets are obtained. The unit can apply a fixed default of 8, 16 or 64 to both offsets. It can instead take both offsets from a one-bit serial stream, or take them from the first two data-bus writes.

The unit runs entirely in the FIFO write clock domain. It drives a ready output that the FIFO uses to refuse normal writes until both offsets are valid. A partial reset is the FIFO's flush. It keeps the chosen method and any offsets already loaded. While the partial reset is held, the unit drops ready and ignores load strobes. Only a master reset starts programming over.

Top module: `fop_unit`

## Requirements
- R1: The select inputs `thr_sel` and `ser_sel` take effect only as sampled at the last rising clock edge with `rst_n` low. Changes to them while `rst_n` is high have no effect.
- R2: `thr_sel` values 1, 2 and 3 set both offsets to 8, 16 and 64, each clamped to DEPTH-1. `cfg_ready` is then high as soon as `rst_n` and `prst_n` are both high.
- R3: When `thr_sel` is 0 and `ser_sel` is 1, one bit of `ser_din` is taken on each clock edge where `ser_en` is high. Edges where `ser_en` is low take no bit. The stream carries the almost-empty offset first and the almost-full offset second, each least significant bit first and OFF_W = clog2(DEPTH) bits long, for 2*OFF_W bits in total.
- R4: When `thr_sel` is 0 and `ser_sel` is 0, the first clock edge with `wr_en` high loads `wr_data` into the almost-empty offset. The second such edge loads the almost-full offset. Each loaded value appears on its offset output one cycle after its edge.
- R5: In the serial and parallel modes, `cfg_ready` stays low until programming is complete. It goes high in the cycle after the edge that takes the last serial bit or the second write.
- R6: Once programming is complete, further `wr_en` or `ser_en` activity leaves both offsets unchanged.
- R7: A loaded offset larger than DEPTH-1 is presented as DEPTH-1.
- R8: While `prst_n` is low, `cfg_ready` is low and load strobes are ignored. The offsets, the mode and the programming progress are all kept, and loading resumes where it stopped once `prst_n` returns high.
- R9: While `rst_n` is low, `cfg_ready` is low. In the serial and parallel modes, a master reset clears both offsets to 0 and restarts programming from the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FIFO write clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset (flush), active low, keeps configuration |
| thr_sel | input | 2 | Default threshold select, sampled during master reset |
| ser_sel | input | 1 | 1 selects serial loading, 0 selects parallel loading, when thr_sel is 0 |
| ser_din | input | 1 | Serial offset data |
| ser_en | input | 1 | Serial shift enable |
| wr_en | input | 1 | Data-bus write strobe |
| wr_data | input | DATA_W | Data-bus write value |
| ae_off | output | OFF_W | Almost-empty offset |
| af_off | output | OFF_W | Almost-full offset |
| cfg_ready | output | 1 | Offsets valid; FIFO may accept normal writes |

## Verification
A partial reset can arrive in the same cycle as a load strobe: either a parallel write or the final serial bit. The bench provokes both collisions. It holds `prst_n` low across an active write, and again across the last serial bit with `ser_en` high. It then checks that `cfg_ready` stays low, that the offset already loaded is unchanged, and that the colliding value is taken only after `prst_n` is released. A master reset that lands in the middle of parallel programming is also driven, to confirm that the next write goes to the almost-empty offset again.

// File: rtl/fop_pkg.sv
// Shared types and helpers for the flag offset programming unit.
// Assumes offsets never need more than 32 bits.
package fop_pkg;

    typedef enum logic [1:0] {
        MODE_DEFAULT  = 2'd0,
        MODE_SERIAL   = 2'd1,
        MODE_PARALLEL = 2'd2
    } fop_mode_e;

    // Saturate a value to an upper limit.
    function automatic logic [31:0] clamp_u32(input logic [31:0] v, input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/fop_mode_latch.sv
// Captures the programming method and the default offset while master reset
// is low. The value seen at the last low-reset edge is kept afterwards.
// Assumes DEPTH >= 2.
module fop_mode_latch
    import fop_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       thr_sel,
    input  logic             ser_sel,
    output fop_mode_e        mode,
    output logic [OFF_W-1:0] def_off
);

    localparam logic [31:0] LIM = 32'(DEPTH - 1);

    logic [31:0] raw_def;

    // Decode the default offset from the threshold select.
    always_comb begin
        unique case (thr_sel)
            2'd1:    raw_def = 32'd8;
            2'd2:    raw_def = 32'd16;
            2'd3:    raw_def = 32'd64;
            default: raw_def = 32'd0;
        endcase
    end

    // Sample the selection on every edge that sees master reset low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (thr_sel == 2'd0)
                mode <= ser_sel ? MODE_SERIAL : MODE_PARALLEL;
            else
                mode <= MODE_DEFAULT;
            def_off <= OFF_W'(clamp_u32(raw_def, LIM));
        end
    end

endmodule

// File: rtl/fop_serial_load.sv
// Shifts in both offsets from a one-bit stream, least significant bit first,
// almost-empty offset first. Stops after 2*OFF_W accepted bits.
// Assumes the caller gates en with the mode and the partial reset.
module fop_serial_load #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ser_din,
    input  logic             ser_en,
    output logic [OFF_W-1:0] ae_raw,
    output logic [OFF_W-1:0] af_raw,
    output logic             done
);

    localparam int NBITS = 2 * OFF_W;
    localparam int CNT_W = $clog2(NBITS + 1);

    logic [NBITS-1:0] shreg;
    logic [CNT_W-1:0] cnt;

    assign done   = (cnt == CNT_W'(NBITS));
    assign ae_raw = shreg[OFF_W-1:0];
    assign af_raw = shreg[NBITS-1:OFF_W];

    // Shift one bit in at the top per enabled edge and count the bits taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (en && ser_en && !done) begin
            shreg <= {ser_din, shreg[NBITS-1:1]};
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fop_parallel_load.sv
// Takes the almost-empty offset from the first enabled write and the
// almost-full offset from the second. Values are clamped at load time.
// Assumes the caller gates en with the mode and the partial reset.
module fop_parallel_load
    import fop_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFF_W-1:0]  ae_q,
    output logic [OFF_W-1:0]  af_q,
    output logic              done
);

    localparam logic [31:0] LIM   = 32'(DEPTH - 1);
    localparam int          SLOTS = 2;

    logic [1:0]       wr_cnt;
    logic [OFF_W-1:0] sat_data;

    assign done     = (wr_cnt == 2'(SLOTS));
    assign sat_data = OFF_W'(clamp_u32(32'(wr_data), LIM));

    // Count accepted configuration writes up to the number of slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_cnt <= '0;
        else if (en && wr_en && !done)
            wr_cnt <= wr_cnt + 1'b1;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [OFF_W-1:0] q;
        // Load this slot on the write whose ordinal matches it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (en && wr_en && (wr_cnt == 2'(k)))
                q <= sat_data;
        end
    end

    assign ae_q = g_slot[0].q;
    assign af_q = g_slot[1].q;

endmodule

// File: rtl/fop_unit.sv
// Flag offset programming unit: picks the offset source at master reset and
// presents the almost-empty and almost-full offsets with a ready flag.
// Assumes a single write-clock domain and synchronous active-low resets.
module fop_unit
    import fop_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int DATA_W = 16,
    localparam int OFF_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic [1:0]        thr_sel,
    input  logic              ser_sel,
    input  logic              ser_din,
    input  logic              ser_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFF_W-1:0]  ae_off,
    output logic [OFF_W-1:0]  af_off,
    output logic              cfg_ready
);

    localparam logic [31:0] LIM = 32'(DEPTH - 1);

    fop_mode_e        mode;
    logic [OFF_W-1:0] def_off;
    logic [OFF_W-1:0] ser_ae, ser_af, par_ae, par_af;
    logic             ser_done, par_done, sel_done;
    logic             ser_go, par_go;

    assign ser_go = prst_n && (mode == MODE_SERIAL);
    assign par_go = prst_n && (mode == MODE_PARALLEL);

    fop_mode_latch #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_sel (thr_sel),
        .ser_sel (ser_sel),
        .mode    (mode),
        .def_off (def_off)
    );

    fop_serial_load #(.OFF_W(OFF_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ser_go),
        .ser_din (ser_din),
        .ser_en  (ser_en),
        .ae_raw  (ser_ae),
        .af_raw  (ser_af),
        .done    (ser_done)
    );

    fop_parallel_load #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (par_go),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ae_q    (par_ae),
        .af_q    (par_af),
        .done    (par_done)
    );

    // Route the offsets and completion of the selected source to the outputs.
    always_comb begin
        unique case (mode)
            MODE_SERIAL: begin
                ae_off   = OFF_W'(clamp_u32(32'(ser_ae), LIM));
                af_off   = OFF_W'(clamp_u32(32'(ser_af), LIM));
                sel_done = ser_done;
            end
            MODE_PARALLEL: begin
                ae_off   = par_ae;
                af_off   = par_af;
                sel_done = par_done;
            end
            default: begin
                ae_off   = def_off;
                af_off   = def_off;
                sel_done = 1'b1;
            end
        endcase
    end

    assign cfg_ready = rst_n && prst_n && sel_done;

endmodule

// File: rtl/fop_unit_chk.sv
// Checker for fop_unit: watches the ready flag and the offset outputs.
module fop_unit_chk #(
    parameter int DEPTH = 256,
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prst_n,
    input logic [OFF_W-1:0] ae_off,
    input logic [OFF_W-1:0] af_off,
    input logic             cfg_ready
);

    // R9: master reset holds ready low
    a_r9_ready_low_in_mreset: assert property (@(posedge clk)
        !rst_n |-> !cfg_ready);

    // R8: partial reset holds ready low
    a_r8_ready_low_in_preset: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |-> !cfg_ready);

    // R8: offsets frozen across a partial-reset cycle
    a_r8_offsets_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> ($stable(ae_off) && $stable(af_off)));

    // R6: offsets frozen once ready
    a_r6_offsets_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> ($stable(ae_off) && $stable(af_off)));

    // R5: ready, once given, is only withdrawn by a reset
    a_r5_ready_persists: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> (cfg_ready || !prst_n));

    // R7: presented offsets never exceed DEPTH-1
    a_r7_offsets_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> ((32'(ae_off) <= 32'(DEPTH - 1)) && (32'(af_off) <= 32'(DEPTH - 1))));

endmodule

bind fop_unit fop_unit_chk #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prst_n    (prst_n),
    .ae_off    (ae_off),
    .af_off    (af_off),
    .cfg_ready (cfg_ready)
);

// File: tb/tb_fop_unit.sv
`timescale 1ns/1ps
module tb_fop_unit;

    localparam int DEPTH  = 256;
    localparam int DATA_W = 16;
    localparam int OFF_W  = 8;
    localparam int NVEC   = 7;

    // {thr_sel, ser_sel, value0, value1, expected ae, expected af}
    localparam logic [50:0] VEC [NVEC] = '{
        {2'd1, 1'b0, 16'd0,    16'd0,   8'd8,   8'd8},
        {2'd2, 1'b1, 16'd0,    16'd0,   8'd16,  8'd16},
        {2'd3, 1'b0, 16'd0,    16'd0,   8'd64,  8'd64},
        {2'd0, 1'b0, 16'd5,    16'd200, 8'd5,   8'd200},
        {2'd0, 1'b0, 16'd1000, 16'd255, 8'd255, 8'd255},
        {2'd0, 1'b1, 16'h003C, 16'h00A5, 8'h3C, 8'hA5},
        {2'd0, 1'b1, 16'd0,    16'd255, 8'd0,   8'd255}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prst_n = 1'b1;
    logic [1:0]        thr_sel = 2'd0;
    logic              ser_sel = 1'b0;
    logic              ser_din = 1'b0;
    logic              ser_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [OFF_W-1:0]  ae_off, af_off;
    logic              cfg_ready;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fop_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .thr_sel(thr_sel),
        .ser_sel(ser_sel), .ser_din(ser_din), .ser_en(ser_en),
        .wr_en(wr_en), .wr_data(wr_data),
        .ae_off(ae_off), .af_off(af_off), .cfg_ready(cfg_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Master reset: a wrong select first, the wanted select at the last low edge,
    // then the selects are scrambled as reset is released (R1).
    task automatic mreset(input logic [1:0] s, input logic ser);
        rst_n = 1'b0; prst_n = 1'b1; wr_en = 1'b0; ser_en = 1'b0;
        thr_sel = ~s; ser_sel = ~ser;
        tick();
        chk("R9 ready low in master reset", int'(cfg_ready), 0);
        thr_sel = s; ser_sel = ser;
        tick();
        rst_n = 1'b1; thr_sel = ~s; ser_sel = ~ser;
    endtask

    task automatic shift_bits(input logic [7:0] a, input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 8) ? a[i] : b[i-8];
            ser_en  = 1'b1;
            tick();
        end
        ser_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Vector table
        for (int n = 0; n < NVEC; n++) begin
            logic [50:0] v;
            logic [1:0]  s;
            logic        sr;
            logic [15:0] v0, v1;
            logic [7:0]  eae, eaf;
            v = VEC[n];
            s = v[50:49]; sr = v[48]; v0 = v[47:32]; v1 = v[31:16];
            eae = v[15:8]; eaf = v[7:0];
            mreset(s, sr);
            tick();
            if (s != 2'd0) begin
                chk("R2 R1 default ready", int'(cfg_ready), 1);
                chk("R2 R1 default ae", int'(ae_off), int'(eae));
                chk("R2 R1 default af", int'(af_off), int'(eaf));
            end else if (!sr) begin
                chk("R9 parallel cleared ae", int'(ae_off), 0);
                chk("R5 parallel not ready", int'(cfg_ready), 0);
                wr_en = 1'b1; wr_data = v0;
                tick();
                chk("R5 not ready after one write", int'(cfg_ready), 0);
                wr_data = v1;
                tick();
                wr_en = 1'b0;
                chk("R5 ready after two writes", int'(cfg_ready), 1);
                chk("R4 R7 parallel ae", int'(ae_off), int'(eae));
                chk("R4 R7 parallel af", int'(af_off), int'(eaf));
                wr_en = 1'b1; wr_data = 16'd3;
                tick();
                wr_en = 1'b0;
                chk("R6 ae after extra write", int'(ae_off), int'(eae));
                chk("R6 af after extra write", int'(af_off), int'(eaf));
            end else begin
                shift_bits(v0[7:0], v1[7:0], 5);
                ser_en = 1'b0; ser_din = ~v0[5];
                tick();
                for (int i = 5; i < 16; i++) begin
                    ser_din = (i < 8) ? v0[i] : v1[i-8];
                    ser_en = 1'b1;
                    tick();
                    if (i == 14) chk("R5 serial not ready before last bit", int'(cfg_ready), 0);
                end
                ser_en = 1'b0;
                chk("R5 serial ready", int'(cfg_ready), 1);
                chk("R3 serial ae", int'(ae_off), int'(eae));
                chk("R3 serial af", int'(af_off), int'(eaf));
                ser_en = 1'b1; ser_din = 1'b1;
                tick(); tick();
                ser_en = 1'b0;
                chk("R6 serial ae held", int'(ae_off), int'(eae));
                chk("R6 serial af held", int'(af_off), int'(eaf));
            end
        end

        // Partial reset coinciding with a parallel write (R8)
        mreset(2'd0, 1'b0);
        wr_en = 1'b1; wr_data = 16'd40;
        tick();
        prst_n = 1'b0; wr_data = 16'd90;
        tick();
        chk("R8 ready low in partial reset", int'(cfg_ready), 0);
        chk("R8 ae kept in partial reset", int'(ae_off), 40);
        chk("R8 write ignored in partial reset", int'(af_off), 0);
        prst_n = 1'b1; wr_data = 16'd77;
        tick();
        wr_en = 1'b0;
        chk("R8 ready after partial reset", int'(cfg_ready), 1);
        chk("R8 ae after partial reset", int'(ae_off), 40);
        chk("R8 af resumes", int'(af_off), 77);

        // Partial reset coinciding with the last serial bit (R8)
        mreset(2'd0, 1'b1);
        shift_bits(8'h12, 8'h34, 15);
        prst_n = 1'b0; ser_en = 1'b1; ser_din = 1'b0;
        tick();
        chk("R8 last bit blocked", int'(cfg_ready), 0);
        prst_n = 1'b1;
        tick();
        ser_en = 1'b0;
        chk("R8 serial ready after release", int'(cfg_ready), 1);
        chk("R8 serial ae", int'(ae_off), 8'h12);
        chk("R8 serial af", int'(af_off), 8'h34);

        // Partial reset in default mode keeps the offsets (R8)
        mreset(2'd3, 1'b1);
        prst_n = 1'b0;
        tick();
        chk("R8 default ready low", int'(cfg_ready), 0);
        chk("R8 default ae kept", int'(ae_off), 64);
        prst_n = 1'b1;
        tick();
        chk("R8 default ready back", int'(cfg_ready), 1);

        // Master reset mid-programming restarts at the almost-empty slot (R9)
        mreset(2'd0, 1'b0);
        wr_en = 1'b1; wr_data = 16'd11;
        tick();
        wr_en = 1'b0;
        mreset(2'd0, 1'b0);
        tick();
        chk("R9 ae cleared by master reset", int'(ae_off), 0);
        wr_en = 1'b1; wr_data = 16'd22;
        tick();
        wr_data = 16'd33;
        tick();
        wr_en = 1'b0;
        chk("R9 first write goes to ae", int'(ae_off), 22);
        chk("R9 second write goes to af", int'(af_off), 33);
        chk("R9 ready after restart", int'(cfg_ready), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule